// File: doc/BRIEF.md
# At-Speed Test Plan Sequencer

This block is the on-chip test controller for a data path put into a structural test mode. It selects one combinational element of the data path by its index and plays out that element's test plan. A test plan is a fixed-length sequence of control vectors, one vector per system clock, and it drives the data path's control inputs along with the extra hold and pass-through controls. Because the sequence comes from on-chip logic running on the system clock, the test patterns reach the element under test at operational speed.

Two small registers set up the run. The target register holds the element index, and the pattern register holds a control-input test value for plans whose data-path inputs are all busy in the cycle where that value is needed. Both registers capture fields of the data-path primary input bus while reset is held and keep their contents once reset is released. A mode pin chooses between two uses of the control-input bus. With the pin low, the functional controller's control word passes straight through and every test element is disabled. With the pin high, the plan sequencer drives the bus.

Top module: `tpg_test_ctrl`

## Requirements
- R1: The target register is max(1, ceil(log2 NUM_MODS)) bits wide and is loaded from `dp_pi[PAT_W +: IDX_W]`. The pattern register is loaded from `dp_pi[PAT_W-1:0]`. Both registers load on every clock while the synchronised reset is low and hold their contents once it is high, so later changes on `dp_pi` do not change which plan runs.
- R2: The reset is asynchronous and active-low, and its release is synchronised over two flops. With `test_mode` high, step 0 of the plan appears on `ctrl_out` after the second rising edge that follows the rise of `rst_n`. The plan then advances one step on each clock.
- R3: For an index k < NUM_MODS at step s, the plan vector is ((k*16 + s)*37 + 11) mod 2^CTRL_W.
- R4: At the injection step s == k mod PLAN_LEN, bits [PAT_W-1:0] of the vector are replaced by the control-input test value.
- R5: The test value comes from a different place depending on k. For even k, a spare primary input is free, so the value is taken live from `dp_pi[PAT_W-1:0]`. For odd k, it is taken from the pattern register.
- R6: One clock after the last step (PLAN_LEN-1) is shown, `plan_done` rises and `ctrl_out` becomes zero. Both stay that way until the next reset.
- R7: While `test_mode` is low, `ctrl_out` equals `func_ctrl`, `dft_en` is 0 and the step counter holds. Raising `test_mode` later starts the plan from step 0.
- R8: A target index of NUM_MODS or above produces all-zero vectors. `plan_done` still rises after PLAN_LEN steps.
- R9: While the synchronised reset is low, `dft_en` is 0 and `ctrl_out` is zero when `test_mode` is high.
- R10: `dft_en` is 1 whenever `test_mode` is high and the synchronised reset is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; also the load strobe for the setup registers |
| test_mode | input | 1 | 1 selects data-path test, 0 selects normal operation |
| dp_pi | input | PI_W | Data-path primary inputs: setup fields during reset, spare test value during the plan |
| func_ctrl | input | CTRL_W | Control word from the functional controller |
| ctrl_out | output | CTRL_W | Control word delivered to the data path |
| dft_en | output | 1 | Enables the hold and pass-through test elements |
| plan_done | output | 1 | High once the selected plan has completed |

## Verification
The bench builds the block with NUM_MODS=6, PLAN_LEN=8, CTRL_W=12, PAT_W=4 and PI_W=16. This makes the target register 3 bits wide, so indices 6 and 7 can be loaded and the out-of-range path can be exercised. With six modules there are injection steps at positions 0 through 5, covering both the live-input source and the stored source. Every index is swept through a full plan while the upper bits of `dp_pi` are changed, which checks that the setup registers hold. Directed runs cover normal-mode passthrough, entering test mode late, and a `plan_done` that stays high.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  // Base control word of plan k at step s (before test-value injection).
  function automatic logic [31:0] plan_word(input int unsigned k, input int unsigned s);
    logic [31:0] acc;
    acc = 32'((k * 32'd16 + s) * 32'd37 + 32'd11);
    return acc;
  endfunction

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/tpg_rst_sync.sv
module tpg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/tpg_setup_regs.sv
module tpg_setup_regs #(
  parameter int PI_W  = 16,
  parameter int PAT_W = 4,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_sync_n,
  input  logic [PI_W-1:0]  dp_pi,
  output logic [IDX_W-1:0] target_idx,
  output logic [PAT_W-1:0] stored_val
);

  logic             load_en;
  logic [IDX_W-1:0] tgt_q, tgt_d;
  logic [PAT_W-1:0] pat_q, pat_d;

  // Loads are tied to reset: capture while held, keep after release.
  assign load_en = ~rst_sync_n;

  always_comb begin
    tgt_d = tgt_q;
    pat_d = pat_q;
    if (load_en) begin
      tgt_d = dp_pi[PAT_W +: IDX_W];
      pat_d = dp_pi[PAT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    tgt_q <= tgt_d;
    pat_q <= pat_d;
  end

  assign target_idx = tgt_q;
  assign stored_val = pat_q;

  // R1: after release, setup registers hold
  a_r1_setup_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rst_sync_n |=> ($stable(tgt_q) && $stable(pat_q)));

endmodule

// File: rtl/tpg_step_seq.sv
module tpg_step_seq #(
  parameter int PLAN_LEN = 8,
  parameter int STEP_W   = 3
) (
  input  logic              clk,
  input  logic              rst_sync_n,
  input  logic              test_mode,
  output logic [STEP_W-1:0] step,
  output logic              done
);

  localparam logic [STEP_W-1:0] LAST = STEP_W'(PLAN_LEN - 1);

  logic [STEP_W-1:0] step_q, step_d;
  logic              done_q, done_d;
  logic              adv;

  assign adv = test_mode & ~done_q;

  always_comb begin
    step_d = step_q;
    done_d = done_q;
    if (adv) begin
      if (step_q == LAST) begin
        done_d = 1'b1;
      end else begin
        step_d = step_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      step_q <= '0;
      done_q <= 1'b0;
    end else begin
      step_q <= step_d;
      done_q <= done_d;
    end
  end

  assign step = step_q;
  assign done = done_q;

  // R2: one step per clock while running
  a_r2_step_advance: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (test_mode && !done_q && step_q != LAST) |=> (step_q == $past(step_q) + 1'b1));

  // R6: done only at the last step, and sticky
  a_r6_done_at_last: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_q |-> (step_q == LAST));
  a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_q |=> done_q);

  // R7: counter frozen in normal mode
  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !test_mode |=> (step_q == $past(step_q)));

endmodule

// File: rtl/tpg_plan_rom.sv
module tpg_plan_rom #(
  parameter int NUM_MODS = 6,
  parameter int PLAN_LEN = 8,
  parameter int CTRL_W   = 12,
  parameter int PAT_W    = 4,
  parameter int IDX_W    = 3,
  parameter int STEP_W   = 3
) (
  input  logic [IDX_W-1:0]  target_idx,
  input  logic [STEP_W-1:0] step,
  input  logic [PAT_W-1:0]  live_val,
  input  logic [PAT_W-1:0]  stored_val,
  output logic [CTRL_W-1:0] vec
);

  localparam int FLAT_W = NUM_MODS * CTRL_W;

  logic [FLAT_W-1:0] flat;

  for (genvar gk = 0; gk < NUM_MODS; gk++) begin : g_mod
    logic [PAT_W-1:0]  tval;
    logic [31:0]       raw;
    logic [CTRL_W-1:0] word;

    // R5: source of the test value is fixed per module
    if ((gk % 2) == 0) begin : g_live
      assign tval = live_val;
    end else begin : g_stored
      assign tval = stored_val;
    end

    always_comb begin
      raw  = tpg_pkg::plan_word(gk, {{(32-STEP_W){1'b0}}, step});
      word = raw[CTRL_W-1:0];
      if (step == STEP_W'(gk % PLAN_LEN)) begin
        word[PAT_W-1:0] = tval;
      end
    end

    assign flat[gk*CTRL_W +: CTRL_W] = word;
  end

  always_comb begin
    vec = '0;
    if (int'(target_idx) < NUM_MODS) begin
      vec = flat[int'(target_idx)*CTRL_W +: CTRL_W];
    end
  end

endmodule

// File: rtl/tpg_test_ctrl.sv
module tpg_test_ctrl #(
  parameter int NUM_MODS = 6,
  parameter int PLAN_LEN = 8,
  parameter int CTRL_W   = 12,
  parameter int PAT_W    = 4,
  parameter int PI_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_mode,
  input  logic [PI_W-1:0]   dp_pi,
  input  logic [CTRL_W-1:0] func_ctrl,
  output logic [CTRL_W-1:0] ctrl_out,
  output logic              dft_en,
  output logic              plan_done
);

  localparam int IDX_W  = tpg_pkg::idx_width(NUM_MODS);
  localparam int STEP_W = tpg_pkg::idx_width(PLAN_LEN);

  logic              rst_sync_n;
  logic [IDX_W-1:0]  target_idx;
  logic [PAT_W-1:0]  stored_val;
  logic [STEP_W-1:0] step;
  logic              done;
  logic [CTRL_W-1:0] plan_vec;

  tpg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tpg_setup_regs #(
    .PI_W  (PI_W),
    .PAT_W (PAT_W),
    .IDX_W (IDX_W)
  ) u_regs (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .dp_pi      (dp_pi),
    .target_idx (target_idx),
    .stored_val (stored_val)
  );

  tpg_step_seq #(
    .PLAN_LEN (PLAN_LEN),
    .STEP_W   (STEP_W)
  ) u_seq (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .test_mode  (test_mode),
    .step       (step),
    .done       (done)
  );

  tpg_plan_rom #(
    .NUM_MODS (NUM_MODS),
    .PLAN_LEN (PLAN_LEN),
    .CTRL_W   (CTRL_W),
    .PAT_W    (PAT_W),
    .IDX_W    (IDX_W),
    .STEP_W   (STEP_W)
  ) u_rom (
    .target_idx (target_idx),
    .step       (step),
    .live_val   (dp_pi[PAT_W-1:0]),
    .stored_val (stored_val),
    .vec        (plan_vec)
  );

  always_comb begin
    if (!test_mode) begin
      ctrl_out = func_ctrl;
    end else if (!rst_sync_n || done) begin
      ctrl_out = '0;
    end else begin
      ctrl_out = plan_vec;
    end
  end

  assign dft_en    = test_mode & rst_sync_n;
  assign plan_done = done;

  // R6: finished plan drives an idle word in test mode
  a_r6_idle_after_done: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (test_mode && plan_done) |-> (ctrl_out == '0));

endmodule

// File: tb/tb_tpg_test_ctrl.sv
module tb_tpg_test_ctrl;

  localparam int NM = 6;
  localparam int PL = 8;
  localparam int CW = 12;
  localparam int PW = 4;
  localparam int IW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          test_mode;
  logic [IW-1:0] dp_pi;
  logic [CW-1:0] func_ctrl;
  logic [CW-1:0] ctrl_out;
  logic          dft_en;
  logic          plan_done;

  int checks = 0;
  int errors = 0;
  bit ended  = 1'b0;

  always #5 clk = ~clk;

  tpg_test_ctrl #(
    .NUM_MODS (NM), .PLAN_LEN (PL), .CTRL_W (CW), .PAT_W (PW), .PI_W (IW)
  ) dut (
    .clk (clk), .rst_n (rst_n), .test_mode (test_mode), .dp_pi (dp_pi),
    .func_ctrl (func_ctrl), .ctrl_out (ctrl_out), .dft_en (dft_en),
    .plan_done (plan_done)
  );

  // Stimulus table: {target index, pattern-register value}
  localparam logic [7:0] STIM [8] = '{
    8'h0_A, 8'h1_5, 8'h2_C, 8'h3_9, 8'h4_3, 8'h5_E, 8'h6_7, 8'h7_1
  };

  function automatic logic [CW-1:0] expect_vec(int k, int s, logic [PW-1:0] tpr,
                                               logic [PW-1:0] spare);
    logic [CW-1:0] w;
    if (k >= NM) return '0;                        // R8
    w = CW'(((k * 16 + s) * 37 + 11));             // R3
    if (s == (k % PL)) begin                       // R4
      w[PW-1:0] = ((k % 2) == 0) ? spare : tpr;    // R5
    end
    return w;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply_reset(int k, logic [PW-1:0] tpr, logic tm);
    @(negedge clk);
    rst_n = 1'b0;
    test_mode = tm;
    dp_pi = IW'((k << PW) | tpr);
    @(posedge clk);
    @(negedge clk);
    check("R9 dft_en in reset", 32'(dft_en), 32'd0);
    if (tm) check("R9 ctrl_out in reset", 32'(ctrl_out), 32'd0);
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_plan(int k, logic [PW-1:0] tpr);
    logic [PW-1:0] spare;
    apply_reset(k, tpr, 1'b1);
    for (int s = 0; s < PL; s++) begin
      spare = PW'(s * 3 + k + 1);
      // upper bits point at another index: R1 says the target must not change
      dp_pi = IW'(((k ^ 7) << PW) | spare);
      #1;
      check("R3/R4/R5 plan vector", 32'(ctrl_out), 32'(expect_vec(k, s, tpr, spare)));
      check("R10 dft_en", 32'(dft_en), 32'd1);
      if (s == PL - 1) check("R6 done low on last step", 32'(plan_done), 32'd0);
      @(posedge clk);
      @(negedge clk);
    end
    check("R6 done raised", 32'(plan_done), 32'd1);
    check("R6 idle word", 32'(ctrl_out), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    test_mode = 1'b0;
    dp_pi = '0;
    func_ctrl = '0;

    // Table walk: every index, including out-of-range ones (R8), R1 and R2 timing
    for (int i = 0; i < 8; i++) begin
      run_plan(int'(STIM[i][7:4]), STIM[i][3:0]);
    end

    // R6: done stays high
    for (int c = 0; c < 3; c++) begin
      @(posedge clk);
      @(negedge clk);
      check("R6 done sticky", 32'(plan_done), 32'd1);
      check("R6 idle sticky", 32'(ctrl_out), 32'd0);
    end

    // R7: normal mode passthrough and held counter
    apply_reset(1, 4'h6, 1'b0);
    for (int c = 0; c < 4; c++) begin
      func_ctrl = CW'(12'h3A5 ^ (c * 12'h111));
      #1;
      check("R7 passthrough", 32'(ctrl_out), 32'(func_ctrl));
      check("R7 dft_en low", 32'(dft_en), 32'd0);
      check("R7 no done", 32'(plan_done), 32'd0);
      @(posedge clk);
      @(negedge clk);
    end
    test_mode = 1'b1;
    #1;
    check("R7 late start step 0", 32'(ctrl_out), 32'(expect_vec(1, 0, 4'h6, 4'h0)));
    @(posedge clk);
    @(negedge clk);
    check("R7 late start step 1", 32'(ctrl_out), 32'(expect_vec(1, 1, 4'h6, 4'h0)));

    // R9: reset reasserted mid-plan clears output at once
    rst_n = 1'b0;
    #1;
    check("R9 async clear", 32'(ctrl_out), 32'd0);
    check("R9 dft_en clear", 32'(dft_en), 32'd0);

    ended = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule